// File: doc/BRIEF.md
# Canonical Signed-Digit Recoder

This block rewrites an unsigned binary constant into canonical signed-digit form. Every digit of the result is -1, 0 or +1, and no two neighbouring digits are both nonzero. A conversion starts with a one-cycle start strobe that carries the constant. The result comes back as two masks, one marking the +1 digits and one marking the -1 digits, together with a one-cycle done strobe. The masks are one bit wider than the input, so that a carry out of the top bit has a place to go. A shift-add multiplier that schedules its steps from the nonzero digits can take the masks directly.

The conversion works by scanning. A pointer walks up from the least significant bit and spends one cycle on each position. At each position it checks whether a run of at least two ones begins there. When it finds one, every one in the run is cleared, a +1 is placed in the bit just above the run, and a -1 is placed at the run's lowest bit. The weighted value does not change. The inserted +1 can join ones that lie above it, so after every replacement the pointer returns to the least significant bit. The conversion is done when one complete pass finds no run. A single one with zeros on both sides is left as it is.

Top module: `csd_recoder`

## Requirements
- R1: After reset, done_o is 0, and pos_o and neg_o are all zeros.
- R2: When done_o is 1, the sum of 2^i over the set bits of pos_o, minus the same sum over the set bits of neg_o, equals value_i as captured at the start.
- R3: When done_o is 1, the OR of pos_o and neg_o contains no two adjacent set bits.
- R4: pos_o and neg_o never have a bit set at the same position.
- R5: The result is the unique non-adjacent form of the input. For example, 0x0E0 (ones at bits 5 to 7) gives pos_o with only bit 8 set and neg_o with only bit 5 set.
- R6: An input that has no two adjacent ones comes back unchanged: pos_o equals the input, zero-extended, and neg_o is zero.
- R7: When the input is all ones, the result is bit W of pos_o set and bit 0 of neg_o set. Bit W of pos_o is never set while bit W-1 of pos_o is also set.
- R8: For an input with no two adjacent ones, done_o rises exactly W cycles after the clock edge that captures start_i.
- R9: start_i is ignored while a conversion is in progress. The result then belongs to the value that was captured first.
- R10: done_o is high for exactly one cycle. After that, pos_o and neg_o hold their values until the next start is accepted.
- R11: A start_i that is high in the cycle in which done_o is high is accepted, and the new conversion begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture value_i and begin a conversion (accepted only when idle) |
| value_i | input | W | Unsigned constant to recode |
| done_o | output | 1 | One-cycle strobe: the result is valid |
| pos_o | output | W+1 | Mask of the +1 digits |
| neg_o | output | W+1 | Mask of the -1 digits |

## Verification
Two events can land on the same clock edge. The first is the end of a conversion, when done_o is raised and the block goes idle. The second is a new start, or a start that arrives while the block is still scanning. The bench raises start_i in the very cycle in which done_o is high and checks that the second constant is captured and recoded correctly. It also pulses start_i with a different constant part-way through a scan and checks that the finished masks still belong to the first constant. Every result is compared against a non-adjacent form computed in the bench, and against the value and adjacency rules.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } csd_state_e;
endpackage

// File: rtl/csd_run_probe.sv
// Reports whether a run of two or more ones starts at the scan position
module csd_run_probe #(
  parameter int W  = 32,
  parameter int IW = 6
) (
  input  logic [W:0]    digits_i,
  input  logic [IW-1:0] idx_i,
  output logic          hit_o,
  output logic          last_o
);
  logic [W:0] shifted;

  always_comb begin
    shifted = digits_i >> idx_i;
    hit_o   = shifted[0] & shifted[1];
    last_o  = (idx_i == IW'(W - 1));
  end
endmodule

// File: rtl/csd_run_replace.sv
// Adding 2^idx ripples through the run: the run clears and the bit above it sets
module csd_run_replace #(
  parameter int W  = 32,
  parameter int IW = 6
) (
  input  logic          en_i,
  input  logic [W:0]    pos_i,
  input  logic [W:0]    neg_i,
  input  logic [IW-1:0] idx_i,
  output logic [W:0]    pos_o,
  output logic [W:0]    neg_o
);
  logic [W:0] unit;

  always_comb begin
    unit  = (W+1)'(1) << idx_i;
    pos_o = en_i ? pos_i + unit : pos_i;
    neg_o = en_i ? (neg_i | unit) : neg_i;
  end
endmodule

// File: rtl/csd_recoder.sv
module csd_recoder
  import csd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] value_i,
  output logic         done_o,
  output logic [W:0]   pos_o,
  output logic [W:0]   neg_o
);
  localparam int IW = $clog2(W + 1) < 1 ? 1 : $clog2(W + 1);

  csd_state_e    state_q;
  logic [W:0]    pos_q, neg_q;
  logic [IW-1:0] idx_q;
  logic          done_q;
  logic          hit, last;
  logic [W:0]    pos_nx, neg_nx;

  csd_run_probe #(.W(W), .IW(IW)) i_probe (
    .digits_i (pos_q),
    .idx_i    (idx_q),
    .hit_o    (hit),
    .last_o   (last)
  );

  csd_run_replace #(.W(W), .IW(IW)) i_replace (
    .en_i  (hit),
    .pos_i (pos_q),
    .neg_i (neg_q),
    .idx_i (idx_q),
    .pos_o (pos_nx),
    .neg_o (neg_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      neg_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            pos_q   <= {1'b0, value_i};
            neg_q   <= '0;
            idx_q   <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (hit) begin
            pos_q <= pos_nx;
            neg_q <= neg_nx;
            idx_q <= '0;  // inserted one may form a new run: rescan
          end else if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign pos_o  = pos_q;
  assign neg_o  = neg_q;

  // R4
  overlap_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q & neg_q) == '0);

  // R3
  adjacent_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (((pos_q | neg_q) & ((pos_q | neg_q) >> 1)) == '0));

  // R2
  value_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && hit) |=> (pos_q - neg_q) == $past(pos_q - neg_q));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> ($stable(pos_q) && $stable(neg_q)));

  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && !last) |=> state_q == ST_SCAN);

  // R7
  top_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_q[W] && pos_q[W-1]));
endmodule

// File: tb/test_csd_recoder.sv
module test_csd_recoder;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 150000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] value_i = '0;
  logic         done_o;
  logic [W:0]   pos_o, neg_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  csd_recoder #(.W(W)) i_csd_recoder (
    .clk_i, .rst_ni, .start_i, .value_i, .done_o, .pos_o, .neg_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2*(W+1)-1:0] naf(input logic [W-1:0] v);
    longint x = longint'(v);
    logic [W:0] p = '0, n = '0;
    for (int i = 0; i <= W; i++) begin
      if (x[0]) begin
        if (x[1]) begin n[i] = 1'b1; x = x + 1; end
        else      begin p[i] = 1'b1; x = x - 1; end
      end
      x = x >>> 1;
    end
    return {p, n};
  endfunction

  function automatic longint weigh(input logic [W:0] m);
    longint s = 0;
    for (int i = 0; i <= W; i++) if (m[i]) s += (longint'(1) << i);
    return s;
  endfunction

  // Waits at negedges for done_o; returns 0 on timeout
  task automatic wait_done(output bit seen);
    seen = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk_i);
      if (done_o) begin seen = 1; return; end
    end
  endtask

  task automatic judge(input logic [W-1:0] v);
    logic [2*(W+1)-1:0] e;
    logic [W:0] any;
    e = naf(v);
    any = pos_o | neg_o;
    check({pos_o, neg_o} == e, "R5", {pos_o, neg_o}, e);
    check(weigh(pos_o) - weigh(neg_o) == longint'(v), "R2",
          weigh(pos_o) - weigh(neg_o), longint'(v));
    check((any & (any >> 1)) == '0, "R3", any, '0);
    check((pos_o & neg_o) == '0, "R4", pos_o & neg_o, '0);
  endtask

  // Start at a negedge, captured at the next posedge
  task automatic convert(input logic [W-1:0] v);
    bit seen;
    @(negedge clk_i);
    start_i = 1'b1; value_i = v;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(seen);
    check(seen, "R10", seen, 1);
    judge(v);
  endtask

  initial begin
    bit seen;
    logic [W:0] hp, hn;
    logic [W-1:0] v;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk_i);
    // R1
    check(done_o == 0 && pos_o == '0 && neg_o == '0, "R1", {done_o, pos_o, neg_o}, '0);
    rst_ni = 1'b1;

    // R5: run at bits 5..7
    convert(32'h0000_00E0);
    check(pos_o == 33'h100 && neg_o == 33'h020, "R5", {pos_o, neg_o}, {33'h100, 33'h020});

    // R7: all ones
    convert('1);
    check(pos_o == (33'h1 << W) && neg_o == 33'h1, "R7", {pos_o, neg_o},
          {33'h1 << W, 33'h1});

    // R6: isolated ones kept
    convert(32'h5555_5555);
    check(pos_o == {1'b0, 32'h5555_5555} && neg_o == '0, "R6", {pos_o, neg_o},
          {1'b0, 32'h5555_5555});
    convert(32'h8000_0001);
    check(pos_o == {1'b0, 32'h8000_0001} && neg_o == '0, "R6", pos_o, 33'h8000_0001);
    convert(32'h0);
    convert(32'h1B);          // carry joins the next run
    convert(32'hB6DB_6DB6);

    // R8: latency on a run-free input
    @(negedge clk_i);
    start_i = 1'b1; value_i = 32'h2492_4924;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (W - 1) @(posedge clk_i);
    @(negedge clk_i);
    check(done_o == 1'b0, "R8", done_o, 0);
    @(negedge clk_i);
    check(done_o == 1'b1, "R8", done_o, 1);
    judge(32'h2492_4924);

    // R10: pulse ends, masks hold while idle
    hp = pos_o; hn = neg_o;
    value_i = 32'hFFFF_0000;
    repeat (5) begin
      @(negedge clk_i);
      check(done_o == 1'b0, "R10", done_o, 0);
    end
    check(pos_o == hp && neg_o == hn, "R10", {pos_o, neg_o}, {hp, hn});

    // R9: start during scan ignored
    @(negedge clk_i);
    start_i = 1'b1; value_i = 32'h0F0F_0F0F;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    start_i = 1'b1; value_i = 32'h1234_5678;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(seen);
    check(seen, "R9", seen, 1);
    judge(32'h0F0F_0F0F);

    // R11: start in the done cycle is accepted
    @(negedge clk_i);
    start_i = 1'b1; value_i = 32'h0000_0077;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(seen);
    check(seen, "R11", seen, 1);
    judge(32'h0000_0077);
    start_i = 1'b1; value_i = 32'hDEAD_BEEF;   // done_o is high now
    @(negedge clk_i);
    start_i = 1'b0;
    check(done_o == 1'b0, "R11", done_o, 0);
    wait_done(seen);
    check(seen, "R11", seen, 1);
    judge(32'hDEAD_BEEF);

    // Random constants, some biased toward long runs
    for (int t = 0; t < 60; t++) begin
      v = $urandom();
      if (t % 3 == 1) v = v | (v >> 1) | (v << 2);
      convert(v);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule